// File: doc/BRIEF.md
# UART Receive Line Status with Break Handling

This block is the receive-side line watcher of a FIFO-based UART, together with the transmitter's occupancy flags. It samples a serial input on a 16x oversample enable and assembles characters made of one start bit, `DATA_BITS` data bits sent LSB first, one even-parity bit and one stop bit. Every received character goes into a receive FIFO together with three tags: parity error, framing error and break. The tags travel with their character. They reach the status word only when that character becomes the FIFO head.

A line held low through a whole character, stop bit included, is a break. A break loads a single all-zero character, tagged as both break and framing error. The receiver then ignores the line until it has seen a full bit time of marking followed by a properly confirmed start bit. A summary bit reports whether any tagged character is still queued.

On the transmit side there is a small holding queue and a shifter that is modelled only by its duration. These drive a ready flag and an empty flag. The input `rxIn` is taken to be synchronous to `clk`.

Top module: `uart_line_status`

## Requirements
- R1: A character is accepted only when the input is low on the 8th oversample tick after a high-to-low transition. Otherwise the start is discarded. The accepted data (LSB first) appears on `rxData`, and `rxReady` (status bit 0) is 1 while the FIFO holds anything.
- R2: When the received parity bit differs from the XOR of the data bits, the character is tagged with a parity error, shown as status bit 1.
- R3: A stop bit sampled low tags the character with a framing error, shown as status bit 2.
- R4: A break is a line held low through the start, data, parity and stop positions. It queues exactly one character. That character has data 0, carries the break tag (status bit 3) and the framing tag, and carries no parity tag.
- R5: After a break, no character is accepted until the input has been high for 16 consecutive oversample ticks and a valid start bit follows.
- R6: Status bits 1 to 3 are sticky. They are set when a tagged character becomes the FIFO head, and a `statusRead` pulse clears them unless a new head arrives in the same cycle.
- R7: Status bit 6 is 1 exactly when at least one queued character carries any tag. It is 0 when the FIFO is empty.
- R8: The FIFO is first-in first-out. A character that arrives when the FIFO is full is dropped, and `rxPop` on an empty FIFO has no effect.
- R9: Status bit 4 (transmit ready) is 1 when the transmit holding queue is empty. It is 0 in the cycle after a `txWrite` accepted into an empty queue. A write into a full queue is dropped.
- R10: Status bit 5 (transmit empty) is 1 only when the queue is empty and the shifter is idle. The shifter holds each character for (DATA_BITS+3)*16 oversample ticks.
- R11: After reset the status word is 7'b0110000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | 16x oversample enable |
| rxIn | input | 1 | Serial receive line, synchronous to clk |
| rxPop | input | 1 | Remove the FIFO head |
| statusRead | input | 1 | Status read strobe; clears the sticky bits |
| txWrite | input | 1 | Queue one character for transmission |
| rxData | output | DATA_BITS | Data of the FIFO head |
| rxReady | output | 1 | FIFO not empty |
| statusWord | output | 7 | {fifoErr, txEmpty, txReady, brk, frm, par, rxReady} |

## Verification
The bench builds the block with a 4-entry receive FIFO and a 2-entry transmit queue. The default depths are kept for `DATA_BITS` and the oversample rate. The shallow receive FIFO lets a handful of characters reach the full and overflow cases. It also lets a break character sit behind a clean one, so the bench can see its tag stay hidden until the clean character is popped. The shallow transmit queue lets the bench fill the queue, drop a fourth write, and then time the drain of exactly three characters through the shifter.

// File: rtl/uls_pkg.sv
package uls_pkg;

  typedef struct packed {
    logic clearChar;
    logic shiftIn;
    logic captureParity;
    logic push;
    logic tagFrame;
    logic tagBreak;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP,
    RX_WAITMARK
  } rxState_t;

endpackage

// File: rtl/uls_rx_ctrl.sv
module uls_rx_ctrl
  import uls_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxIn,
  output rxStrobe_t  strobe
);
  localparam int OS_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam int HALF  = OVERSAMPLE / 2;

  rxState_t          state, stateNext;
  logic [OS_W-1:0]   tickCnt, tickNext;
  logic [BIT_W-1:0]  bitCnt, bitNext;
  logic              sawOne, sawOneNext;
  logic              lastSample;

  // Mid-bit sample point: the last tick of each bit window.
  logic midBit;
  assign midBit = (tickCnt == OS_W'(OVERSAMPLE - 1));

  always_comb begin
    stateNext  = state;
    tickNext   = tickCnt;
    bitNext    = bitCnt;
    sawOneNext = sawOne;
    strobe     = '0;
    if (sampleTick) begin
      unique case (state)
        RX_IDLE: begin
          if (lastSample && !rxIn) begin
            stateNext = RX_START;
            tickNext  = '0;
          end
        end
        RX_START: begin
          if (tickCnt == OS_W'(HALF - 1)) begin
            tickNext = '0;
            if (!rxIn) begin
              stateNext        = RX_DATA;
              bitNext          = '0;
              sawOneNext       = 1'b0;
              strobe.clearChar = 1'b1;
            end else begin
              stateNext = RX_IDLE;
            end
          end else begin
            tickNext = tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (midBit) begin
            tickNext       = '0;
            strobe.shiftIn = 1'b1;
            sawOneNext     = sawOne | rxIn;
            if (bitCnt == BIT_W'(DATA_BITS - 1)) stateNext = RX_PARITY;
            else                                 bitNext   = bitCnt + 1'b1;
          end else begin
            tickNext = tickCnt + 1'b1;
          end
        end
        RX_PARITY: begin
          if (midBit) begin
            tickNext             = '0;
            strobe.captureParity = 1'b1;
            sawOneNext           = sawOne | rxIn;
            stateNext            = RX_STOP;
          end else begin
            tickNext = tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (midBit) begin
            tickNext        = '0;
            strobe.push     = 1'b1;
            strobe.tagFrame = !rxIn;
            strobe.tagBreak = !rxIn && !sawOne;
            stateNext       = (!rxIn && !sawOne) ? RX_WAITMARK : RX_IDLE;
          end else begin
            tickNext = tickCnt + 1'b1;
          end
        end
        RX_WAITMARK: begin
          if (!rxIn)      tickNext  = '0;
          else if (midBit) stateNext = RX_IDLE;
          else            tickNext  = tickCnt + 1'b1;
        end
        default: stateNext = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= RX_IDLE;
      tickCnt    <= '0;
      bitCnt     <= '0;
      sawOne     <= 1'b0;
      lastSample <= 1'b1;
    end else begin
      state   <= stateNext;
      tickCnt <= tickNext;
      bitCnt  <= bitNext;
      sawOne  <= sawOneNext;
      if (sampleTick) lastSample <= rxIn;
    end
  end

endmodule

// File: rtl/uls_datapath.sv
module uls_datapath
  import uls_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter int RX_DEPTH   = 16,
  parameter int TX_DEPTH   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxIn,
  input  rxStrobe_t            strobe,
  input  logic                 rxPop,
  input  logic                 statusRead,
  input  logic                 txWrite,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic [2:0]           stickyTags,
  output logic                 errInFifo,
  output logic                 txReady,
  output logic                 txEmpty,
  output logic                 headArrive
);
  localparam int PTR_W    = $clog2(RX_DEPTH);
  localparam int CNT_W    = PTR_W + 1;
  localparam int ENTRY_W  = DATA_BITS + 3;
  localparam int TX_TICKS = (DATA_BITS + 3) * OVERSAMPLE;
  localparam int TXC_W    = $clog2(TX_DEPTH + 1);
  localparam int TXT_W    = $clog2(TX_TICKS);

  // ---------------- receive character assembly ----------------
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parityBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else if (strobe.clearChar) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strobe.shiftIn)       shiftReg  <= {rxIn, shiftReg[DATA_BITS-1:1]};
      if (strobe.captureParity) parityBit <= rxIn;
    end
  end

  // Entry layout: {break, frame, parity, data}
  logic [ENTRY_W-1:0] pushEntry;
  assign pushEntry = {strobe.tagBreak, strobe.tagFrame, ^{shiftReg, parityBit}, shiftReg};

  // ---------------- receive FIFO ----------------
  logic [ENTRY_W-1:0] mem [RX_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count, errCnt;
  logic               doPush, doPop;
  logic [ENTRY_W-1:0] headEntry, arriveEntry;

  assign doPush    = strobe.push && (count != CNT_W'(RX_DEPTH));
  assign doPop     = rxPop && (count != '0);
  assign headEntry = mem[rdPtr];

  always_comb begin
    headArrive  = 1'b0;
    arriveEntry = pushEntry;
    if (doPop && count >= CNT_W'(2)) begin
      headArrive  = 1'b1;
      arriveEntry = mem[rdPtr + PTR_W'(1)];
    end else if (doPush && (count == '0 || (doPop && count == CNT_W'(1)))) begin
      headArrive = 1'b1;
    end
  end

  logic pushTagged, popTagged;
  assign pushTagged = doPush && (|pushEntry[ENTRY_W-1:DATA_BITS]);
  assign popTagged  = doPop  && (|headEntry[ENTRY_W-1:DATA_BITS]);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      errCnt     <= '0;
      stickyTags <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count      <= count + CNT_W'(doPush) - CNT_W'(doPop);
      errCnt     <= errCnt + CNT_W'(pushTagged) - CNT_W'(popTagged);
      stickyTags <= (statusRead ? 3'b000 : stickyTags)
                  | (headArrive ? arriveEntry[ENTRY_W-1:DATA_BITS] : 3'b000);
    end
  end

  assign rxData    = headEntry[DATA_BITS-1:0];
  assign rxReady   = (count != '0);
  assign errInFifo = (errCnt != '0);

  // ---------------- transmitter occupancy ----------------
  logic [TXC_W-1:0] txCount;
  logic [TXT_W-1:0] txTicks;
  logic             txBusy, txLoad, txAccept;

  assign txLoad   = !txBusy && (txCount != '0);
  assign txAccept = txWrite && (txCount != TXC_W'(TX_DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCount <= '0;
      txBusy  <= 1'b0;
      txTicks <= '0;
    end else begin
      txCount <= txCount + TXC_W'(txAccept) - TXC_W'(txLoad);
      if (txLoad) begin
        txBusy  <= 1'b1;
        txTicks <= '0;
      end else if (txBusy && sampleTick) begin
        if (txTicks == TXT_W'(TX_TICKS - 1)) txBusy  <= 1'b0;
        else                                 txTicks <= txTicks + 1'b1;
      end
    end
  end

  assign txReady = (txCount == '0);
  assign txEmpty = (txCount == '0) && !txBusy;

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter int RX_DEPTH   = 16,
  parameter int TX_DEPTH   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxIn,
  input  logic                 rxPop,
  input  logic                 statusRead,
  input  logic                 txWrite,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic [6:0]           statusWord
);
  rxStrobe_t  strobe;
  logic [2:0] stickyTags;
  logic       errInFifo, txReady, txEmpty, headArrive;

  uls_rx_ctrl #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn), .strobe(strobe)
  );

  uls_datapath #(
    .DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE),
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn), .strobe(strobe),
    .rxPop(rxPop), .statusRead(statusRead), .txWrite(txWrite),
    .rxData(rxData), .rxReady(rxReady), .stickyTags(stickyTags),
    .errInFifo(errInFifo), .txReady(txReady), .txEmpty(txEmpty),
    .headArrive(headArrive)
  );

  // stickyTags is {break, frame, parity}
  assign statusWord = {errInFifo, txEmpty, txReady,
                       stickyTags[2], stickyTags[1], stickyTags[0], rxReady};

endmodule

// File: rtl/uls_checker.sv
module uls_checker (
  input logic       clk,
  input logic       rstN,
  input logic       statusRead,
  input logic       txWrite,
  input logic       headArrive,
  input logic [6:0] statusWord
);
  assert_no_tag_when_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[0] |-> !statusWord[6]);

  assert_empty_implies_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[5] |-> statusWord[4]);

  assert_write_drops_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    txWrite && statusWord[4] |=> !statusWord[4]);

  assert_read_clears_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusRead && !headArrive |=> statusWord[3:1] == 3'b000);
endmodule

bind uart_line_status uls_checker u_chk (
  .clk(clk), .rstN(rstN), .statusRead(statusRead), .txWrite(txWrite),
  .headArrive(headArrive), .statusWord(statusWord)
);

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int TX_CLKS    = 11 * BIT_CLKS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxIn = 1'b1;
  logic       rxPop = 1'b0;
  logic       statusRead = 1'b0;
  logic       txWrite = 1'b0;
  logic [7:0] rxData;
  logic       rxReady;
  logic [6:0] statusWord;

  int checks = 0;
  int errors = 0;
  int divCnt = 0;
  bit finished = 1'b0;

  uart_line_status #(.DATA_BITS(8), .OVERSAMPLE(16), .RX_DEPTH(4), .TX_DEPTH(2)) u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn), .rxPop(rxPop),
    .statusRead(statusRead), .txWrite(txWrite), .rxData(rxData),
    .rxReady(rxReady), .statusWord(statusWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    divCnt     <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    sampleTick <= (divCnt == TICK_DIV - 1);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic holdLine(input logic val, input int bits);
    rxIn = val;
    repeat (bits * BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic badPar, input logic badStop);
    holdLine(1'b0, 1);
    for (int i = 0; i < 8; i++) holdLine(d[i], 1);
    holdLine((^d) ^ badPar, 1);
    holdLine(!badStop, 1);
    holdLine(1'b1, 2);
  endtask

  task automatic sendBreak();
    holdLine(1'b0, 22);
    holdLine(1'b1, 2);
  endtask

  task automatic pulsePop();
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic pulseRead();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic pulseWrite();
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic testReset();
    chk("R11 status after reset", statusWord, 7'b0110000);
    chk("R11 rxReady after reset", rxReady, 0);
  endtask

  task automatic testNormal();
    sendChar(8'hA5, 0, 0);
    chk("R1 data 0xA5", rxData, 8'hA5);
    chk("R1 clean status", statusWord, 7'b0110001);
    pulsePop();
    sendChar(8'h3C, 0, 0);
    chk("R1 data 0x3C", rxData, 8'h3C);
    pulsePop();
    chk("R1 empty after pop", rxReady, 0);
    // false start: low for only 4 ticks
    holdLine(1'b0, 0); rxIn = 1'b0; repeat (4 * TICK_DIV) @(negedge clk);
    holdLine(1'b1, 12);
    chk("R1 short glitch discarded", rxReady, 0);
  endtask

  task automatic testParity();
    sendChar(8'h81, 1, 0);
    chk("R2 data kept", rxData, 8'h81);
    chk("R2 parity tag visible", statusWord[1], 1);
    chk("R7 summary set", statusWord[6], 1);
    pulseRead();
    chk("R6 read clears parity", statusWord[1], 0);
    chk("R7 summary survives read", statusWord[6], 1);
    pulsePop();
    chk("R7 summary clears on pop", statusWord[6], 0);
  endtask

  task automatic testFrame();
    sendChar(8'h42, 0, 1);
    chk("R3 frame tag", statusWord[3:1], 3'b010);
    pulseRead();
    pulsePop();
  endtask

  task automatic testBreak();
    sendBreak();
    chk("R4 break data zero", rxData, 0);
    chk("R4 break and frame tags", statusWord[3:1], 3'b110);
    chk("R4 summary", statusWord[6], 1);
    pulseRead();
    pulsePop();
    chk("R4 exactly one break character", rxReady, 0);
  endtask

  task automatic testRearm();
    holdLine(1'b0, 22);
    pulsePop();
    rxIn = 1'b1; repeat (4 * TICK_DIV) @(negedge clk);
    sendChar(8'h00, 0, 0);
    chk("R5 character after short mark ignored", rxReady, 0);
    sendChar(8'h5A, 0, 0);
    chk("R5 accepted after rearm", rxReady, 1);
    chk("R5 data after rearm", rxData, 8'h5A);
    pulseRead();
    pulsePop();
  endtask

  task automatic testFollow();
    sendChar(8'h11, 0, 0);
    sendBreak();
    chk("R6 break hidden behind clean head", statusWord[3], 0);
    chk("R7 summary sees queued break", statusWord[6], 1);
    pulsePop();
    chk("R6 break shows at head", statusWord[3:1], 3'b110);
    chk("R6 break head data", rxData, 0);
    pulseRead();
    pulsePop();
  endtask

  task automatic testOverflow();
    for (int i = 1; i <= 5; i++) sendChar(8'(i), 0, 0);
    for (int i = 1; i <= 4; i++) begin
      chk("R8 fifo order", rxData, i);
      pulsePop();
    end
    chk("R8 fifth dropped", rxReady, 0);
    pulsePop();
    chk("R8 pop on empty ignored", statusWord, 7'b0110000);
  endtask

  task automatic testTx();
    chk("R9 ready idle", statusWord[5:4], 2'b11);
    pulseWrite();
    chk("R9 ready drops after write", statusWord[5:4], 2'b00);
    @(negedge clk);
    chk("R10 shifter busy, queue empty", statusWord[5:4], 2'b01);
    repeat (TX_CLKS + 10) @(negedge clk);
    chk("R10 empty after one character", statusWord[5], 1);
    for (int i = 0; i < 4; i++) pulseWrite();
    chk("R9 queue occupied", statusWord[4], 0);
    repeat (2 * TX_CLKS + 200) @(negedge clk);
    chk("R10 still busy mid-drain", statusWord[5], 0);
    repeat (TX_CLKS - 100) @(negedge clk);
    chk("R9 fourth write dropped, drained", statusWord[5:4], 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testParity();
    testFrame();
    testBreak();
    testRearm();
    testFollow();
    testOverflow();
    testTx();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule